// File: doc/BRIEF.md
# Round-Robin Split and Remerge Stream Pipeline

This block takes one 32-bit valid/ready stream and hides two slow lane workers behind it. Words are dealt to the lanes in strict rotation, starting with lane 0. Each lane buffers its words in a queue, passes them through a worker that can start at most one word every four cycles with a fixed two-cycle latency, and buffers the results in a second queue. A merger visits the lanes in the same rotation, so words leave in the order they arrived. The block has no start or done control. It moves data whenever data is present and the output accepts it.

Each lane worker only copies its word. The value of the block lies in the scheduling around the workers. Lane queues absorb a burst at one word per cycle. The merger can drain buffered results at one word per cycle. The worker issue rate, summed over the lanes, bounds the long-run throughput.

Top module: `rr_remerge_pipe`

## Requirements
- R1: While `rst_n` is low at a clock edge, all queues are emptied, both rotation pointers return to lane 0 and the worker stages are cleared. After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Accepted word k, counting from 0 after reset, goes to lane k mod 2. The lane pointer advances only on an accepted input word.
- R3: The output sequence equals the input sequence. No word is lost, duplicated or reordered, under any pattern of `in_valid` gaps and `out_ready` back-pressure.
- R4: Each lane holds 16 words between splitter and worker and 16 words between worker and merger. When the selected lane's input queue is full, `in_ready` is 0 and the splitter waits for that lane without moving to another one. With the output blocked, exactly 64 words are accepted.
- R5: A lane worker starts a new word no sooner than 4 cycles after its previous start. It never starts unless its result queue is certain to have room.
- R6: Every word a worker reads is written to its result queue exactly 2 cycles later. A lone word accepted at edge E0 after reset makes `out_valid` rise after edge E0+3.
- R7: While lane result queues hold data and `out_ready` is 1, the merger delivers one word per cycle. A burst of 50 words offered on consecutive cycles to an empty block with `out_ready` high is accepted without a stall cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value.
- R9: The merger waits on an empty selected lane and does not skip it. Its lane pointer advances only on a completed output handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all logic on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 32 | Input stream word |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block takes the input word this cycle |
| out_data | output | 32 | Output stream word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the output word this cycle |

## Verification
The hardest state to reach is every queue in both lanes full at once, with the splitter stalled on lane 0 and both workers held back by result-queue credit. The stimulus reaches it by holding `out_ready` low and offering words continuously for several hundred cycles. It then counts the accepted words, which must be exactly 64 with `in_ready` low. Releasing the output then shows 32 back-to-back words leaving. The stimulus also checks a lone word's latency right after reset, runs a stall-free 50-word ramp, and runs a long mix of random back-pressure and input gaps, all against an ordered scoreboard.

// File: rtl/rr_pkg.sv
// Package: rr_pkg
// Shared defaults for the split/remerge pipeline. The defaults describe a
// two-lane build with 32-bit words, 16-deep lane queues and workers that
// issue once every four cycles with a two-cycle latency.
package rr_pkg;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_LANES  = 2;
    localparam int DEF_DEPTH  = 16;
    localparam int DEF_II     = 4;
    localparam int DEF_LAT    = 2;
endpackage

// File: rtl/lane_fifo.sv
// Module: lane_fifo
// Synchronous single-clock queue with a registered occupancy count.
// The head word is presented combinationally on pop_data.
// Assumes the users never push when full or pop when empty. The
// assertions below guard both conditions.
module lane_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic              full,
    output logic              empty,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;

    assign full     = (count == DEPTH_C);
    assign empty    = (count == '0);
    assign level    = count;
    assign pop_data = mem[rd_ptr];

    // Storage write: data only, no reset needed.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // R4: a lane queue never takes a word beyond its depth.
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop))
        else $error("lane_fifo push while full");

    // R4: a lane queue is never read while empty.
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty)
        else $error("lane_fifo pop while empty");
endmodule

// File: rtl/lane_worker.sv
// Module: lane_worker
// Copy worker with a bounded issue rate and a fixed latency. A word is
// read from the source queue at most once every II cycles. LAT cycles
// after the read, it is written to the destination queue.
// Assumes LAT < DEPTH. Issue is gated by a credit check against the
// destination level, so the write can never be refused.
module lane_worker #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int II     = 4,
    parameter int LAT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_empty,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_pop,
    input  logic [$clog2(DEPTH+1)-1:0] dst_level,
    input  logic              dst_full,
    output logic              dst_push,
    output logic [DATA_W-1:0] dst_data
);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int GAP_W = $clog2(II+1);
    localparam logic [CNT_W-1:0] DEPTH_C   = CNT_W'(DEPTH);
    localparam logic [GAP_W-1:0] II_M1     = GAP_W'(II - 1);
    localparam logic [GAP_W-1:0] II_C      = GAP_W'(II);

    logic [LAT-1:0]    stg_vld;
    logic [DATA_W-1:0] stg_dat [LAT];
    logic [GAP_W-1:0]  cool;
    logic [CNT_W-1:0]  inflight;
    logic [CNT_W-1:0]  free_slots;
    logic              start;

    // Count words already in the stages: each will need one slot.
    always_comb begin
        inflight = '0;
        for (int i = 0; i < LAT; i++) inflight = inflight + CNT_W'(stg_vld[i]);
    end

    assign free_slots = DEPTH_C - dst_level;
    assign start      = !src_empty && (cool == '0) && (free_slots > inflight);
    assign src_pop    = start;
    assign dst_push   = stg_vld[LAT-1];
    assign dst_data   = stg_dat[LAT-1];

    // Issue-interval counter: reload on a start, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)         cool <= '0;
        else if (start)     cool <= II_M1;
        else if (cool != 0) cool <= cool - 1'b1;
    end

    // Latency stages: valid bits shift each cycle, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) stg_vld <= '0;
        else        stg_vld <= {stg_vld[LAT-2+((LAT>1)?0:1):0], start};
    end

    // Data stages: follow the valid bits, no reset required.
    always_ff @(posedge clk) begin
        stg_dat[0] <= src_data;
        for (int i = 1; i < LAT; i++) stg_dat[i] <= stg_dat[i-1];
    end

    // Checker state: cycles since the last start, saturating at II.
    logic [GAP_W-1:0] gap_chk;
    always_ff @(posedge clk) begin
        if (!rst_n)           gap_chk <= II_C;
        else if (start)       gap_chk <= '0;
        else if (gap_chk != II_C) gap_chk <= gap_chk + 1'b1;
    end

    // R5: two starts are separated by at least II cycles.
    p_start_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (gap_chk >= II_M1))
        else $error("lane_worker issued too early");

    // R5: the credit check keeps the result queue from overflowing.
    p_dst_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dst_push |-> !dst_full)
        else $error("lane_worker wrote into a full queue");
endmodule

// File: rtl/rr_splitter.sv
// Module: rr_splitter
// Deals input words to the lanes in strict rotation, starting at lane 0.
// Stalls on a full selected lane rather than skipping it.
module rr_splitter #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [LANES-1:0] lane_full,
    output logic [LANES-1:0] lane_push
);
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(LANES - 1);

    logic [SEL_W-1:0] sel;
    logic             take;

    assign in_ready = !lane_full[sel];
    assign take     = in_valid && in_ready;

    // Decode the accepted word onto the selected lane.
    always_comb begin
        lane_push = '0;
        lane_push[sel] = take;
    end

    // Rotation pointer: advance after each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n)    sel <= '0;
        else if (take) sel <= (sel == LAST_SEL) ? '0 : sel + 1'b1;
    end

    // R2: a stalled word keeps its lane; the pointer does not move.
    p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> $stable(sel))
        else $error("splitter skipped a full lane");

    // R2: at most one lane receives a word per cycle.
    p_one_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_push))
        else $error("splitter pushed into several lanes");
endmodule

// File: rtl/rr_merger.sv
// Module: rr_merger
// Visits the lane result queues in the same rotation as the splitter and
// presents the head word of the selected lane. Waits on an empty lane.
module rr_merger #(
    parameter int DATA_W = 32,
    parameter int LANES  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [LANES-1:0]             lane_empty,
    input  logic [LANES-1:0][DATA_W-1:0] lane_data,
    output logic [LANES-1:0]             lane_pop,
    output logic                         out_valid,
    output logic [DATA_W-1:0]            out_data,
    input  logic                         out_ready
);
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(LANES - 1);

    logic [SEL_W-1:0] sel;
    logic             fire;

    assign out_valid = !lane_empty[sel];
    assign out_data  = lane_data[sel];
    assign fire      = out_valid && out_ready;

    // Read the selected lane on a completed output handshake.
    always_comb begin
        lane_pop = '0;
        lane_pop[sel] = fire;
    end

    // Rotation pointer: advance only on a completed handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)    sel <= '0;
        else if (fire) sel <= (sel == LAST_SEL) ? '0 : sel + 1'b1;
    end

    // R8: a refused output word stays valid and unchanged.
    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
        else $error("output word changed under back-pressure");

    // R9: no handshake, no movement of the merge pointer.
    p_merge_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(sel))
        else $error("merger skipped a lane");
endmodule

// File: rtl/rr_remerge_pipe.sv
// Module: rr_remerge_pipe
// Top of the split/remerge pipeline. One generate loop builds each lane
// from an input queue, a worker and a result queue. The splitter and
// merger share the same rotation order, so word order is preserved.
// Free running: data moves whenever it is present.
module rr_remerge_pipe
    import rr_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int LANES  = DEF_LANES,
    parameter int DEPTH  = DEF_DEPTH,
    parameter int II     = DEF_II,
    parameter int LAT    = DEF_LAT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [LANES-1:0]             in_full, in_empty, in_push, in_pop;
    logic [LANES-1:0][CNT_W-1:0]  in_lvl;
    logic [LANES-1:0][DATA_W-1:0] in_head;
    logic [LANES-1:0]             rs_full, rs_empty, rs_push, rs_pop;
    logic [LANES-1:0][CNT_W-1:0]  rs_lvl;
    logic [LANES-1:0][DATA_W-1:0] rs_wdata, rs_head;

    rr_splitter #(.LANES(LANES)) u_split (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .lane_full (in_full),
        .lane_push (in_push)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_in_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (in_push[g]),
            .push_data (in_data),
            .pop       (in_pop[g]),
            .pop_data  (in_head[g]),
            .full      (in_full[g]),
            .empty     (in_empty[g]),
            .level     (in_lvl[g])
        );

        lane_worker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .II(II), .LAT(LAT)) u_work (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_empty (in_empty[g]),
            .src_data  (in_head[g]),
            .src_pop   (in_pop[g]),
            .dst_level (rs_lvl[g]),
            .dst_full  (rs_full[g]),
            .dst_push  (rs_push[g]),
            .dst_data  (rs_wdata[g])
        );

        lane_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rs_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (rs_push[g]),
            .push_data (rs_wdata[g]),
            .pop       (rs_pop[g]),
            .pop_data  (rs_head[g]),
            .full      (rs_full[g]),
            .empty     (rs_empty[g]),
            .level     (rs_lvl[g])
        );

        // R4: the splitter never feeds a lane whose queue is at depth.
        p_lane_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_lvl[g] == DEPTH_C) |-> !in_push[g])
            else $error("splitter fed a full lane");
    end

    rr_merger #(.DATA_W(DATA_W), .LANES(LANES)) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_empty (rs_empty),
        .lane_data  (rs_head),
        .lane_pop   (rs_pop),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_ready  (out_ready)
    );
endmodule

// File: tb/tb_rr_remerge_pipe.sv
// Directed bench for rr_remerge_pipe. One task per scenario.
// Inputs change 1 ns after a rising edge; outputs are sampled on falling edges.
module tb_rr_remerge_pipe;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] out_data;
    logic        out_valid;
    logic        out_ready = 1'b0;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q [$];

    always #10 clk = ~clk;   // 50 MHz

    rr_remerge_pipe dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready)
    );

    // Scoreboard: record accepted words, compare delivered words in order (R3).
    always @(negedge clk) begin
        if (rst_n) begin
            if (in_valid && in_ready) exp_q.push_back(in_data);
            if (out_valid && out_ready) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R3: unexpected word actual=%0d expected=none", out_data);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    if (out_data !== e) begin
                        fails++;
                        $display("FAIL R3: order actual=%0d expected=%0d", out_data, e);
                    end
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        exp_q.delete();
    endtask

    task automatic send(input logic [31:0] v, inout int stalls);
        in_valid = 1'b1; in_data = v;
        @(negedge clk);
        while (!in_ready) begin stalls++; @(negedge clk); end
        @(posedge clk); #1 in_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        int t = 0;
        out_ready = 1'b1;
        while (exp_q.size() != 0 && t < 3000) begin @(negedge clk); t++; end
        check(req, exp_q.size(), 0);
    endtask

    // R1: state right after reset.
    task automatic test_reset();
        do_reset();
        @(negedge clk);
        check("R1 in_ready", int'(in_ready), 1);
        check("R1 out_valid", int'(out_valid), 0);
    endtask

    // R6: a lone word appears LAT+1 cycles after its acceptance edge.
    task automatic test_latency();
        int k = 0;
        do_reset();
        out_ready = 1'b1; in_valid = 1'b1; in_data = 32'd77;
        @(negedge clk);
        @(posedge clk); #1 in_valid = 1'b0;
        @(negedge clk);
        while (!out_valid && k < 20) begin k++; @(negedge clk); end
        check("R6 latency", k, 3);
        check("R6 data", int'(out_data), 77);
        drain("R6 drain");
    endtask

    // R2/R3/R7: 50-word ramp without back-pressure, no input stall.
    task automatic test_ramp();
        int stalls = 0;
        do_reset();
        out_ready = 1'b1;
        for (int i = 0; i < 50; i++) send(32'(i), stalls);
        check("R7 ramp stalls", stalls, 0);
        drain("R3 ramp delivered");
    endtask

    // R2/R4/R7: output blocked, all queues fill; then a back-to-back drain.
    task automatic test_fill();
        int acc = 0;
        int run = 0;
        do_reset();
        in_valid = 1'b1; in_data = 32'd1000;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (in_ready) begin
                acc++;
                @(posedge clk); #1 in_data = in_data + 1;
            end else begin
                @(posedge clk); #1;
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
        check("R4 accepted with output blocked", acc, 64);
        check("R4 in_ready low when full", int'(in_ready), 0);
        check("R8 out_valid held", int'(out_valid), 1);
        @(posedge clk); #1 out_ready = 1'b1;
        for (int c = 0; c < 32; c++) begin
            @(negedge clk);
            if (out_valid) run++;
        end
        check("R7 back-to-back output", run, 32);
        drain("R3 fill delivered");
    endtask

    // R3/R8/R9: random output back-pressure and input gaps.
    task automatic test_backpressure();
        int stalls = 0;
        bit done = 1'b0;
        do_reset();
        fork
            begin
                for (int i = 0; i < 200; i++) begin
                    send(32'(5000 + i * 3), stalls);
                    if (($urandom % 4) == 0) begin @(posedge clk); #1; end
                end
                done = 1'b1;
            end
            begin
                while (!done) begin
                    @(posedge clk); #1 out_ready = (($urandom % 3) != 0);
                end
            end
        join
        drain("R9 backpressure delivered");
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        test_reset();
        test_latency();
        test_ramp();
        test_fill();
        test_backpressure();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule